// File: doc/BRIEF.md
# Multi-Phase Beat Bit Extractor

This block turns the beat signals of a coherent-sampling random source into a serial stream. Outside the block, a tapped delay line produces several phase-shifted copies of one free-running oscillator. Each copy enters this block on one tap input, and every tap is sampled by the same sampling clock. After a two-stage synchronizer, each pair of neighbouring taps is XORed. The XOR result is high while a beat edge lies between those two taps. That window gates a pulse-width counter for its channel.

When a channel's window closes, the parity of its count is taken as one random bit. One sweep of the beat edge across the taps therefore yields one bit for each active channel, where a plain coherent sampler gives a single bit per beat period. The number of active channels m is chosen at run time from four values. A small per-channel holding slot queues the captured bits. The slots drain onto a single output, at most one bit per clock with a valid strobe. A sticky flag reports a bit that was lost because its slot was still occupied.

Top module: `phase_bit_extractor`

## Requirements
- R1: Each tap input passes through two sampling-clock registers before use. A window that opens at the clock edge k, when the taps are captured, and stays open for H edges presents its bit on the output after edge k+H+3.
- R2: The window of channel i is the XOR of synchronized taps i and i+1. No other tap pair gates a channel.
- R3: A channel counter restarts at 1 on the first cycle of its window and adds one for each further cycle the window stays high. It holds while the window is low. The bit captured when the window closes is the count LSB, so an odd window width gives 1 and an even width gives 0.
- R4: The channel-count select mode_i uses the encoding 0 = 2 channels, 1 = 3 channels, 2 = 6 channels, 3 = 9 channels.
- R5: Channels with index m or above never produce a bit, even when their tap pair toggles.
- R6: A sweep of the beat edge from tap 0 to the last tap produces exactly m bits, in channel order.
- R7: When several channels close their windows on the same edge, the lower channel index is emitted first.
- R8: At most one bit is emitted per clock. bit_valid_o lasts one cycle per bit, and bit_o is 0 whenever bit_valid_o is low.
- R9: overrun_o is set when a channel captures while its slot is occupied and that slot is not emitted on that edge. Once set, the flag stays set until reset.
- R10: While rst_n is low and after its release, bit_valid_o, bit_o and overrun_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock from the second oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_i | input | MAX_CH+1 | Delayed copies of the sampled oscillator, tap 0 earliest |
| mode_i | input | 2 | Active channel count select (0:2, 1:3, 2:6, 3:9) |
| bit_o | output | 1 | Extracted random bit |
| bit_valid_o | output | 1 | bit_o carries a new bit this cycle |
| overrun_o | output | 1 | Sticky flag: a captured bit was dropped |

## Verification
The hardest situation to reach from the ports is an overrun, because a slot drains one cycle after its capture unless lower channels keep winning the output. The stimulus toggles the taps between all-zero and an alternating pattern on every edge, so that every channel opens and closes a one-cycle window every two cycles. With two channels the drain rate keeps up and no bit is dropped. With three or more channels the slots fill faster than one per cycle can empty them, which forces the flag. Equal-edge closing is reached by a tap pattern in which two neighbouring windows end on the same edge with different widths, so that the emission order can be seen in the bit values.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
  localparam int unsigned MAX_CH = 9;

  typedef enum logic [1:0] {
    CH_TWO   = 2'd0,
    CH_THREE = 2'd1,
    CH_SIX   = 2'd2,
    CH_NINE  = 2'd3
  } ch_mode_e;

  function automatic logic [MAX_CH-1:0] active_mask(input ch_mode_e mode);
    int unsigned n;
    logic [MAX_CH-1:0] mask;
    unique case (mode)
      CH_TWO:   n = 2;
      CH_THREE: n = 3;
      CH_SIX:   n = 6;
      default:  n = 9;
    endcase
    for (int unsigned i = 0; i < MAX_CH; i++) mask[i] = (i < n);
    return mask;
  endfunction
endpackage

// File: rtl/pbx_tap_sync.sv
module pbx_tap_sync #(
  parameter int unsigned WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= raw_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/pbx_chan_counter.sv
module pbx_chan_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] count_o,
  output logic             cap_o,
  output logic             cap_bit_o
);
  logic             gate_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             gate_d;
  logic             cnt_en;

  always_comb begin
    gate_d = active_i & gate_i;
    cnt_en = 1'b1;
    cnt_d  = cnt_q;
    if (!active_i) begin
      cnt_d = '0;
    end else if (gate_i && !gate_q) begin
      cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (gate_i) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      gate_q <= gate_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cap_o     = active_i & gate_q & ~gate_i;
  assign cap_bit_o = cnt_q[0];
  assign count_o   = cnt_q;
endmodule

// File: rtl/pbx_merge.sv
module pbx_merge #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] active_i,
  input  logic [N-1:0] cap_i,
  input  logic [N-1:0] cap_bit_i,
  output logic [N-1:0] grant_o,
  output logic         bit_o,
  output logic         valid_o,
  output logic         overrun_o
);
  logic [N-1:0] pend_q, pend_d;
  logic [N-1:0] val_q, val_d;
  logic [N-1:0] grant;
  logic         bit_d, valid_d, ovf_d;
  logic         bit_q, valid_q, ovf_q;
  logic         found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int unsigned i = 0; i < N; i++) begin
      if (pend_q[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
    valid_d = found;
    bit_d   = |(grant & val_q);
    pend_d  = pend_q & ~grant;
    val_d   = val_q;
    for (int unsigned i = 0; i < N; i++) begin
      if (cap_i[i]) begin
        pend_d[i] = 1'b1;
        val_d[i]  = cap_bit_i[i];
      end
    end
    pend_d = pend_d & active_i;
    ovf_d  = ovf_q | (|(cap_i & pend_q & ~grant));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      val_q   <= '0;
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      val_q   <= val_d;
      bit_q   <= bit_d;
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
    end
  end

  assign grant_o   = grant;
  assign bit_o     = bit_q;
  assign valid_o   = valid_q;
  assign overrun_o = ovf_q;
endmodule

// File: rtl/phase_bit_extractor.sv
module phase_bit_extractor
  import pbx_pkg::*;
#(
  parameter int unsigned CH_MAX = MAX_CH,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned NTAP  = CH_MAX + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTAP-1:0] tap_i,
  input  logic [1:0]      mode_i,
  output logic            bit_o,
  output logic            bit_valid_o,
  output logic            overrun_o
);
  logic [NTAP-1:0]   tap_s;
  logic [CH_MAX-1:0] gate_w;
  logic [CH_MAX-1:0] chan_en;
  logic [CH_MAX-1:0] cap_w;
  logic [CH_MAX-1:0] cap_bit_w;
  logic [CH_MAX-1:0] grant_w;
  logic [CNT_W-1:0]  cnt_w [CH_MAX];
  logic [MAX_CH-1:0] mask_full;

  assign mask_full = active_mask(ch_mode_e'(mode_i));

  pbx_tap_sync #(.WIDTH(NTAP)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  (tap_i),
    .sync_o (tap_s)
  );

  for (genvar g = 0; g < CH_MAX; g++) begin : g_chan
    if (g < MAX_CH) begin : g_on
      assign chan_en[g] = mask_full[g];
    end else begin : g_off
      assign chan_en[g] = 1'b0;
    end
    assign gate_w[g] = tap_s[g] ^ tap_s[g+1];

    pbx_chan_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (chan_en[g]),
      .gate_i    (gate_w[g]),
      .count_o   (cnt_w[g]),
      .cap_o     (cap_w[g]),
      .cap_bit_o (cap_bit_w[g])
    );
  end

  pbx_merge #(.N(CH_MAX)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .active_i  (chan_en),
    .cap_i     (cap_w),
    .cap_bit_i (cap_bit_w),
    .grant_o   (grant_w),
    .bit_o     (bit_o),
    .valid_o   (bit_valid_o),
    .overrun_o (overrun_o)
  );
endmodule

// File: rtl/phase_bit_extractor_chk.sv
module phase_bit_extractor_chk #(
  parameter int unsigned N     = 9,
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_o,
  input logic             bit_valid_o,
  input logic             overrun_o,
  input logic [N-1:0]     gate_w,
  input logic [N-1:0]     chan_en,
  input logic [N-1:0]     cap_w,
  input logic [N-1:0]     grant_w,
  input logic [CNT_W-1:0] cnt0
);
  // R8: no data on the output without a strobe
  a_r8_quiet_bit: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid_o |-> !bit_o);

  // R9: the overrun flag never clears on its own
  a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  // R5: a disabled channel never captures
  a_r5_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_w & ~chan_en) == '0);

  // R3: the counter restarts at 1 when its window opens
  a_r3_rise_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en[0] && gate_w[0] && !$past(gate_w[0])) |=> (cnt0 == 1));

  // R3: a capture happens only as the window closes
  a_r3_capture_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    cap_w[0] |-> (!gate_w[0] && $past(gate_w[0])));

  // R7: at most one slot emitted per cycle
  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_w));

  // R8: a grant always shows up as a strobe on the next cycle
  a_r8_grant_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_w != '0) |=> bit_valid_o);
endmodule

bind phase_bit_extractor phase_bit_extractor_chk #(.N(CH_MAX), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_o       (bit_o),
  .bit_valid_o (bit_valid_o),
  .overrun_o   (overrun_o),
  .gate_w      (gate_w),
  .chan_en     (chan_en),
  .cap_w       (cap_w),
  .grant_w     (grant_w),
  .cnt0        (cnt_w[0])
);

// File: tb/phase_bit_extractor_bench.sv
module phase_bit_extractor_bench;
  localparam int NTAP = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NTAP-1:0] tap = '0;
  logic [1:0]      mode = 2'd0;
  logic            bit_o, bit_valid_o, overrun_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rx_n = 0;
  logic rx_b [64];
  int   rx_t [64];

  always #2.5 clk = ~clk;

  phase_bit_extractor u_phase_bit_extractor (
    .clk         (clk),
    .rst_n       (rst_n),
    .tap_i       (tap),
    .mode_i      (mode),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o),
    .overrun_o   (overrun_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (bit_valid_o && rx_n < 64) begin
      rx_b[rx_n] = bit_o;
      rx_t[rx_n] = cyc;
      rx_n = rx_n + 1;
    end
  end

  typedef struct packed {
    logic [1:0]  mode;
    logic [35:0] widths;
    logic [8:0]  bits;
    logic [3:0]  nbits;
  } vec_t;

  // R4 R6 R3: mode code, window widths per channel (nibble i = channel i),
  // expected bit per channel, expected bit count
  localparam vec_t VEC [5] = '{
    '{2'd0, 36'h987654321, 9'b000000001, 4'd2},
    '{2'd1, 36'h555555322, 9'b000000100, 4'd3},
    '{2'd2, 36'h111642531, 9'b000000111, 4'd6},
    '{2'd3, 36'hFEDCBA987, 9'b101010101, 4'd9},
    '{2'd3, 36'h276321144, 9'b010101100, 4'd9}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic [NTAP-1:0] v, input int n);
    tap = v;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [NTAP-1:0] thermo(input int p);
    logic [NTAP-1:0] t;
    for (int j = 0; j < NTAP; j++) t[j] = (j < p);
    return t;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors = errors + 1;
    checks = checks + 1;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int c0;
    // R10: reset state
    repeat (3) @(negedge clk);
    check(!bit_valid_o && !bit_o && !overrun_o, "R10 during reset", bit_valid_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!bit_valid_o && !bit_o && !overrun_o, "R10 after release", bit_valid_o, 0);

    // table of sweeps
    for (int v = 0; v < 5; v++) begin
      mode = VEC[v].mode;
      hold('0, 4);
      rx_n = 0;
      for (int i = 0; i < 9; i++) hold(thermo(i + 1), int'(VEC[v].widths[4*i +: 4]));
      hold(thermo(NTAP), 4);
      hold('0, 14);
      check(rx_n == int'(VEC[v].nbits), "R6 bit count", rx_n, int'(VEC[v].nbits));
      for (int i = 0; i < int'(VEC[v].nbits); i++)
        if (i < rx_n) check(rx_b[i] == VEC[v].bits[i], "R3 R6 bit value", rx_b[i], VEC[v].bits[i]);
      check(!overrun_o, "R9 no overrun on sweep", overrun_o, 0);
    end

    // R1: latency of a 3-cycle window on channel 0
    mode = 2'd3;
    hold('0, 4);
    rx_n = 0;
    c0 = cyc;
    hold(10'b0000000001, 3);
    hold('0, 10);
    check(rx_n == 1, "R1 one bit", rx_n, 1);
    check(rx_t[0] == c0 + 7, "R1 latency", rx_t[0] - c0, 7);
    check(rx_b[0] == 1'b1, "R3 odd width", rx_b[0], 1);

    // R2 R5: window only on channel 4 while two channels are active
    mode = 2'd0;
    hold('0, 4);
    rx_n = 0;
    hold(10'b1111100000, 3);
    hold('0, 10);
    check(rx_n == 0, "R5 disabled channel silent", rx_n, 0);

    // R2: channel 4 emits once active
    mode = 2'd2;
    hold('0, 4);
    rx_n = 0;
    hold(10'b1111100000, 4);
    hold('0, 10);
    check(rx_n == 1 && rx_b[0] == 1'b0, "R2 pair 4/5 gates channel 4", rx_n, 1);

    // R7: channels 0 (width 2) and 1 (width 1) close on the same edge
    mode = 2'd0;
    hold('0, 4);
    rx_n = 0;
    hold(10'b0000000001, 1);
    hold(10'b0000000010, 1);
    hold('0, 10);
    check(rx_n == 2, "R7 two bits", rx_n, 2);
    check(rx_b[0] == 1'b0 && rx_b[1] == 1'b1, "R7 lower index first", {rx_b[0], rx_b[1]}, 1);
    check(rx_t[1] == rx_t[0] + 1, "R8 one bit per cycle", rx_t[1] - rx_t[0], 1);

    // R9: fast toggling, two channels keep up
    mode = 2'd0;
    for (int k = 0; k < 10; k++) begin
      hold(10'b0101010101, 1);
      hold('0, 1);
    end
    hold('0, 12);
    check(!overrun_o, "R9 two channels no overrun", overrun_o, 0);

    // R9: fast toggling, nine channels overflow
    mode = 2'd3;
    for (int k = 0; k < 10; k++) begin
      hold(10'b0101010101, 1);
      hold('0, 1);
    end
    hold('0, 12);
    check(overrun_o, "R9 overrun set", overrun_o, 1);
    hold('0, 5);
    check(overrun_o, "R9 overrun sticky", overrun_o, 1);

    // R10: reset clears the flag
    rst_n = 1'b0;
    @(negedge clk);
    check(!overrun_o && !bit_valid_o, "R10 reset clears", overrun_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule